// File: doc/BRIEF.md
# Next Program Counter Generator

This block works out the fetch address that follows the current instruction. It offers four ways to move the program counter. Plain sequential fetch steps it forward by one instruction. A conditional branch adds a scaled, signed displacement to the sequential address. A region jump swaps in a new low part of the address and keeps the high part of the sequential address. A register jump takes an operand as the full target. The decode logic supplies the current PC, the control kind, the two immediate fields, the branch outcome and the register operand. The block returns the chosen address, a return address for calls, and a flag that marks a register target that is not word aligned.

All three outputs are registered, so they reflect the inputs sampled at the previous rising clock edge. The fetch stage can therefore use them directly as the next PC register.

Top module: `npc_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs become `npc_o` = RESET_PC (default 0), `link_o` = 0, `link_we_o` = 0 and `misalign_o` = 0.
- R2: When `kind_i` = 2'b00 (sequential), `npc_o` becomes `pc_i` + 4, wrapping modulo 2^64.
- R3: When `kind_i` = 2'b01 (conditional branch) and `taken_i` = 1, `npc_o` becomes `pc_i` + 4 + 4 × sign-extended `imm16_i`. A set bit 15 gives a backward target.
- R4: When `kind_i` = 2'b01 and `taken_i` = 0, `npc_o` becomes `pc_i` + 4.
- R5: When `kind_i` = 2'b10 (region jump), `npc_o` becomes {bits 63..28 of `pc_i`+4, `idx26_i`, 2'b00}. The high bits come from the incremented PC, even when that increment crosses into the next 256 MB region.
- R6: When `kind_i` = 2'b11 (register jump), `npc_o` becomes `regv_i` unchanged, all 64 bits.
- R7: `misalign_o` is 1 exactly when `kind_i` = 2'b11 and `regv_i[1:0]` is nonzero. The target is still passed through unchanged.
- R8: When `call_i` = 1, `link_we_o` = 1 and `link_o` = `pc_i` + 4, for any `kind_i`. When `call_i` = 0, both are 0.
- R9: `taken_i` has no effect on `npc_o` unless `kind_i` = 2'b01.
- R10: Every output changes only at a rising edge, and it reflects the inputs sampled at that edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 64 | Address of the current instruction |
| kind_i | input | 2 | Control kind: 00 sequential, 01 branch, 10 region jump, 11 register jump |
| imm16_i | input | 16 | Signed branch displacement, in instructions |
| idx26_i | input | 26 | Instruction index for the region jump |
| taken_i | input | 1 | Branch condition outcome |
| regv_i | input | 64 | Register operand used as a jump target |
| call_i | input | 1 | Instruction writes a return address |
| npc_o | output | 64 | Next fetch address |
| link_o | output | 64 | Return address, or 0 when there is no call |
| link_we_o | output | 1 | Return address write enable |
| misalign_o | output | 1 | Register target is not word aligned |

## Verification
The only state in this block is the output register. A fault in it, or in the selection in front of it, shows up at the ports on the very next rising edge as a wrong address, a wrong return value or a stray flag. Nothing is kept beyond one cycle, so an error never builds up. Each control kind is driven with values that expose its particular fault. Sign extension is checked with a backward branch. The region boundary is checked with a PC whose increment crosses 256 MB. Wrap-around is checked at the top of the address space. The flag is checked with each nonzero pattern of the low two bits. Checks made just before an edge confirm that nothing reaches the outputs early.

// File: rtl/npc_pkg.sv
package npc_pkg;
    localparam int PC_W        = 64;
    localparam int OFF_W       = 16;
    localparam int IDX_W       = 26;
    localparam int INSTR_BYTES = 4;
    localparam int ALIGN_SH    = $clog2(INSTR_BYTES);
    localparam int REGION_W    = IDX_W + ALIGN_SH;

    typedef enum logic [1:0] {
        FLOW_SEQ    = 2'b00,
        FLOW_BRANCH = 2'b01,
        FLOW_REGION = 2'b10,
        FLOW_REG    = 2'b11
    } flow_kind_e;

    typedef struct packed {
        logic [PC_W-1:0] npc;
        logic [PC_W-1:0] link;
        logic            link_we;
        logic            misalign;
    } npc_res_t;
endpackage

// File: rtl/npc_incr.sv
module npc_incr
    import npc_pkg::*;
(
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] pc4_o
);
    always_comb pc4_o = pc_i + PC_W'(INSTR_BYTES);
endmodule

// File: rtl/npc_branch_unit.sv
module npc_branch_unit
    import npc_pkg::*;
(
    input  logic [PC_W-1:0]  pc4_i,
    input  logic [OFF_W-1:0] imm_i,
    input  logic             taken_i,
    output logic [PC_W-1:0]  target_o
);
    localparam int EXT_W = PC_W - OFF_W - ALIGN_SH;

    logic [PC_W-1:0] disp;

    always_comb begin
        disp     = {{EXT_W{imm_i[OFF_W-1]}}, imm_i, {ALIGN_SH{1'b0}}};
        target_o = taken_i ? (pc4_i + disp) : pc4_i;
    end
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  flow_kind_e       kind_i,
    input  logic [PC_W-1:0]  pc4_i,
    input  logic [PC_W-1:0]  br_target_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [PC_W-1:0]  regv_i,
    input  logic             call_i,
    output npc_res_t         res_o
);
    logic [PC_W-1:0] region_target;
    logic            reg_low_bad;

    always_comb region_target = {pc4_i[PC_W-1:REGION_W], idx_i, {ALIGN_SH{1'b0}}};

    generate
        if (ALIGN_SH > 0) begin : g_align_chk
            always_comb reg_low_bad = |regv_i[ALIGN_SH-1:0];
        end else begin : g_no_align_chk
            always_comb reg_low_bad = 1'b0;
        end
    endgenerate

    always_comb begin
        res_o.misalign = 1'b0;
        unique case (kind_i)
            FLOW_SEQ:    res_o.npc = pc4_i;
            FLOW_BRANCH: res_o.npc = br_target_i;
            FLOW_REGION: res_o.npc = region_target;
            default: begin
                res_o.npc      = regv_i;
                res_o.misalign = reg_low_bad;
            end
        endcase
        res_o.link_we = call_i;
        res_o.link    = call_i ? pc4_i : '0;
    end

    // R5: region jump keeps the upper part of the sequential address
    always_comb begin
        if (kind_i == FLOW_REGION)
            a_region_hi_r5: assert (res_o.npc[PC_W-1:REGION_W] == pc4_i[PC_W-1:REGION_W]);
    end
endmodule

// File: rtl/npc_gen.sv
module npc_gen
    import npc_pkg::*;
#(
    parameter logic [63:0] RESET_PC = 64'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] pc_i,
    input  logic [1:0]  kind_i,
    input  logic [15:0] imm16_i,
    input  logic [25:0] idx26_i,
    input  logic        taken_i,
    input  logic [63:0] regv_i,
    input  logic        call_i,
    output logic [63:0] npc_o,
    output logic [63:0] link_o,
    output logic        link_we_o,
    output logic        misalign_o
);
    logic [PC_W-1:0] pc4;
    logic [PC_W-1:0] br_target;
    npc_res_t        res_d;
    npc_res_t        res_q;

    npc_incr u_incr (
        .pc_i  (pc_i),
        .pc4_o (pc4)
    );

    npc_branch_unit u_branch (
        .pc4_i    (pc4),
        .imm_i    (imm16_i),
        .taken_i  (taken_i),
        .target_o (br_target)
    );

    npc_select u_select (
        .kind_i      (flow_kind_e'(kind_i)),
        .pc4_i       (pc4),
        .br_target_i (br_target),
        .idx_i       (idx26_i),
        .regv_i      (regv_i),
        .call_i      (call_i),
        .res_o       (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '{npc: RESET_PC, link: '0, link_we: 1'b0, misalign: 1'b0};
        end else begin
            res_q <= res_d;
        end
    end

    always_comb begin
        npc_o      = res_q.npc;
        link_o     = res_q.link;
        link_we_o  = res_q.link_we;
        misalign_o = res_q.misalign;
    end

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (npc_o == RESET_PC && !link_we_o && !misalign_o && link_o == '0));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 2'b00) |=> (npc_o == $past(pc_i) + 64'd4));

    p_not_taken_r4: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 2'b01 && !taken_i) |=> (npc_o == $past(pc_i) + 64'd4));

    p_reg_target_r6: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 2'b11) |=> (npc_o == $past(regv_i)));

    p_misalign_kind_r7: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (misalign_o == ($past(kind_i) == 2'b11 && $past(regv_i[1:0]) != 2'b00)));

    p_link_value_r8: assert property (@(posedge clk) disable iff (rst)
        call_i |=> (link_we_o && link_o == $past(pc_i) + 64'd4));

    p_no_link_r8: assert property (@(posedge clk) disable iff (rst)
        !call_i |=> (!link_we_o && link_o == '0));
endmodule

// File: tb/test_npc_gen.sv
module test_npc_gen;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] pc_i;
    logic [1:0]  kind_i;
    logic [15:0] imm16_i;
    logic [25:0] idx26_i;
    logic        taken_i;
    logic [63:0] regv_i;
    logic        call_i;
    logic [63:0] npc_o;
    logic [63:0] link_o;
    logic        link_we_o;
    logic        misalign_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    npc_gen i_npc_gen (
        .clk(clk), .rst(rst), .pc_i(pc_i), .kind_i(kind_i), .imm16_i(imm16_i),
        .idx26_i(idx26_i), .taken_i(taken_i), .regv_i(regv_i), .call_i(call_i),
        .npc_o(npc_o), .link_o(link_o), .link_we_o(link_we_o), .misalign_o(misalign_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // drive at a falling edge, pass one rising edge, sample at the next falling edge
    task automatic step(input logic [1:0] k, input logic [63:0] pc, input logic [15:0] imm,
                        input logic [25:0] idx, input logic tk, input logic [63:0] rv,
                        input logic cl);
        kind_i = k; pc_i = pc; imm16_i = imm; idx26_i = idx;
        taken_i = tk; regv_i = rv; call_i = cl;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [63:0] br_exp(input logic [63:0] pc, input logic [15:0] imm);
        logic signed [63:0] s;
        s = $signed(imm);
        return pc + 64'd4 + 64'(s * 4);
    endfunction

    task automatic t_reset;
        rst = 1'b1;
        step(2'b11, 64'h123, 16'h0, 26'h0, 1'b1, 64'h7, 1'b1);
        chk("R1 npc", npc_o, 64'h0);
        chk("R1 link", link_o, 64'h0);
        chk("R1 we", {63'd0, link_we_o}, 64'd0);
        chk("R1 mis", {63'd0, misalign_o}, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_seq;
        step(2'b00, 64'h0000_0000_4000_1000, 16'h0, 26'h0, 1'b0, 64'h0, 1'b0);
        chk("R2 seq", npc_o, 64'h0000_0000_4000_1004);
        step(2'b00, 64'hFFFF_FFFF_FFFF_FFFC, 16'h0, 26'h0, 1'b0, 64'h0, 1'b0);
        chk("R2 wrap", npc_o, 64'h0);
    endtask

    task automatic t_branch;
        step(2'b01, 64'h1000, 16'h0010, 26'h0, 1'b1, 64'h0, 1'b0);
        chk("R3 fwd", npc_o, br_exp(64'h1000, 16'h0010));
        chk("R3 fwd const", npc_o, 64'h1044);
        step(2'b01, 64'h0000_0001_0000_0000, 16'h8000, 26'h0, 1'b1, 64'h0, 1'b0);
        chk("R3 back", npc_o, 64'h0000_0000_FFFE_0004);
        step(2'b01, 64'h2000, 16'hFFFF, 26'h0, 1'b1, 64'h0, 1'b0);
        chk("R3 minus1", npc_o, 64'h2000);
        step(2'b01, 64'h2000, 16'h7FFF, 26'h0, 1'b0, 64'h0, 1'b0);
        chk("R4 not taken", npc_o, 64'h2004);
    endtask

    task automatic t_region;
        step(2'b10, 64'hABCD_0000_3000_0010, 16'h0, 26'h3FF_FFFF, 1'b0, 64'h0, 1'b0);
        chk("R5 region", npc_o, 64'hABCD_0000_3FFF_FFFC);
        step(2'b10, 64'h0000_0000_0FFF_FFFC, 16'h0, 26'h000_0001, 1'b0, 64'h0, 1'b0);
        chk("R5 cross", npc_o, 64'h0000_0000_1000_0004);
    endtask

    task automatic t_regjump;
        step(2'b11, 64'h40, 16'h0, 26'h0, 1'b0, 64'h8765_4321_0FED_CBA8, 1'b0);
        chk("R6 target", npc_o, 64'h8765_4321_0FED_CBA8);
        chk("R7 aligned", {63'd0, misalign_o}, 64'd0);
        for (int b = 1; b < 4; b++) begin
            step(2'b11, 64'h40, 16'h0, 26'h0, 1'b0, 64'h9000 | 64'(b), 1'b0);
            chk("R7 flag", {63'd0, misalign_o}, 64'd1);
            chk("R7 target", npc_o, 64'h9000 | 64'(b));
        end
        step(2'b10, 64'h40, 16'h0, 26'h5, 1'b0, 64'h3, 1'b0);
        chk("R7 other kind", {63'd0, misalign_o}, 64'd0);
    endtask

    task automatic t_link;
        step(2'b10, 64'h5000, 16'h0, 26'h10, 1'b0, 64'h0, 1'b1);
        chk("R8 link", link_o, 64'h5004);
        chk("R8 we", {63'd0, link_we_o}, 64'd1);
        step(2'b11, 64'h6000, 16'h0, 26'h0, 1'b0, 64'h100, 1'b1);
        chk("R8 reg call", link_o, 64'h6004);
        step(2'b00, 64'h7000, 16'h0, 26'h0, 1'b0, 64'h0, 1'b0);
        chk("R8 no link", link_o, 64'h0);
        chk("R8 no we", {63'd0, link_we_o}, 64'd0);
    endtask

    task automatic t_taken_ignored;
        step(2'b00, 64'h8000, 16'h0100, 26'h0, 1'b1, 64'h0, 1'b0);
        chk("R9 seq", npc_o, 64'h8004);
        step(2'b10, 64'h8000, 16'h0100, 26'h22, 1'b1, 64'h0, 1'b0);
        chk("R9 region", npc_o, 64'h88);
        step(2'b11, 64'h8000, 16'h0100, 26'h0, 1'b1, 64'hC0, 1'b0);
        chk("R9 reg", npc_o, 64'hC0);
    endtask

    task automatic t_latency;
        step(2'b00, 64'hA000, 16'h0, 26'h0, 1'b0, 64'h0, 1'b0);
        kind_i = 2'b11; regv_i = 64'hDEAD_BEE0; call_i = 1'b1;
        #1;
        chk("R10 hold npc", npc_o, 64'hA004);
        chk("R10 hold we", {63'd0, link_we_o}, 64'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R10 update", npc_o, 64'hDEAD_BEE0);
    endtask

    initial begin
        rst = 1'b1; kind_i = 2'b00; pc_i = '0; imm16_i = '0; idx26_i = '0;
        taken_i = 1'b0; regv_i = '0; call_i = 1'b0;
        @(negedge clk);
        t_reset();
        t_seq();
        t_branch();
        t_region();
        t_regjump();
        t_link();
        t_taken_ignored();
        t_latency();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule